// File: doc/BRIEF.md
# Per-Connection Descriptor Chain Scheduler

The block holds pending transmit descriptors for up to sixteen connections. It keeps one singly linked chain per connection in a shared pool of 64 slots. A host presents one transmit entry at a time: a descriptor pointer, a connection index and a set of option bits. Ordinary entries join the tail of their connection's chain. An urgent entry with the link-at-head option joins the front instead, so that a management cell leaves ahead of traffic that is already queued. The block rejects an urgent entry that would break the rules for urgent entries and pulses an error flag for it.

A downstream segmenter asks for work with a pop request. The block serves the non-empty chains in round-robin order, one descriptor per grant. For each grant it presents the descriptor on its output together with a completion record. The record names the status queue that must receive the completion: the global management queue for management descriptors, otherwise the connection's own queue from a per-connection table. It also repeats the descriptor's single-buffer option. A single-buffer descriptor always stands for exactly one cell and never joins or ends a multi-descriptor packet.

Top module: `desc_chain_sched`

## Requirements
- R1: After reset every chain is empty and all 64 slots are free: a pop request produces no output, out_valid and in_err are 0, and 64 entries are accepted without back-pressure.
- R2: An entry is taken only in a cycle where in_valid is 1 and in_stall is 0. The host holds the entry while in_stall is 1, and lowers in_valid once the entry has been taken.
- R3: Entries with in_head=0 are appended at the tail of their connection's chain and are popped in arrival order.
- R4: An accepted entry with in_head=1 is placed in front of the current first descriptor of its connection's chain, so it is popped next for that connection.
- R5: An entry with in_head=1 and in_chained=1 is consumed without being linked, and in_err is 1 in the cycle after it is taken.
- R6: A connection is mid-packet when the last descriptor popped from it had in_single=0 and in_last=0. An entry with in_head=1 and in_single=0 for a connection that is mid-packet is rejected in the same way as in R5.
- R7: For a popped descriptor with in_single=1, out_last is 1 whatever its in_last value was, and the pop leaves the connection's mid-packet state unchanged.
- R8: sts_queue equals mgmt_sq when the descriptor had in_mgmt=1. Otherwise it equals conn_sq_tbl[c*SQ_W +: SQ_W], where c is the connection.
- R9: sts_single and sts_mgmt repeat the descriptor's in_single and in_mgmt bits.
- R10: in_stall is 1 while a valid, non-rejected entry waits and no slot is free. A pop frees one slot, and the held entry is then taken.
- R11: On a pop, the granted connection is the first non-empty one after the last granted connection, in cyclic index order. Connection 0 is checked first after reset. Each grant pops one descriptor.
- R12: out_valid and the output fields appear in the cycle after the edge where pop_req=1 met a non-empty chain. An entry offered in that pop cycle sees in_stall=1 and is taken later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Transmit entry present |
| in_ptr | input | PTR_W | Descriptor pointer |
| in_conn | input | CONN_W | Connection index |
| in_head | input | 1 | Link at head of chain |
| in_single | input | 1 | Single-buffer descriptor option |
| in_chained | input | 1 | Descriptor carries a further linked descriptor |
| in_mgmt | input | 1 | Report completion to the management queue |
| in_last | input | 1 | Descriptor ends its packet |
| in_stall | output | 1 | Back-pressure: hold the entry |
| in_err | output | 1 | Previous entry was rejected |
| conn_sq_tbl | input | NUM_CONN*SQ_W | Status queue index per connection |
| mgmt_sq | input | SQ_W | Management status queue index |
| pop_req | input | 1 | Downstream asks for one descriptor |
| out_valid | output | 1 | Popped descriptor and completion record valid |
| out_ptr | output | PTR_W | Popped descriptor pointer |
| out_conn | output | CONN_W | Connection of popped descriptor |
| out_last | output | 1 | Popped descriptor ends a packet |
| sts_queue | output | SQ_W | Status queue for the completion record |
| sts_single | output | 1 | Single-buffer indicator in the record |
| sts_mgmt | output | 1 | Management indicator in the record |

## Verification
A damaged link or head pointer shows up on out_ptr at the very next pop from that connection: a descriptor comes out of order, twice, or not at all. The bench compares every popped pointer against an order it keeps itself. A damaged free mask shows up either as back-pressure before 64 descriptors are queued or as a missing stall after 64 are queued, so the fill test exposes it within one pass. Errors in mid-packet tracking or queue routing show up on the in_err flag or on the record of the next pop, one cycle after the edge that causes them.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  typedef struct packed {
    logic single;
    logic mgmt;
    logic last;
  } desc_flags_t;

  // A single-buffer descriptor is always a one-cell packet of its own
  function automatic logic ends_packet(input desc_flags_t f);
    return f.last | f.single;
  endfunction

  // New mid-packet state after popping a descriptor
  function automatic logic next_mid(input logic cur, input desc_flags_t f);
    return f.single ? cur : ~f.last;
  endfunction

endpackage

// File: rtl/dcs_slot_pool.sv
module dcs_slot_pool #(
  parameter int NUM_SLOT = 64,
  localparam int SLOT_W = $clog2(NUM_SLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic              rel,
  input  logic [SLOT_W-1:0] rel_idx,
  output logic [SLOT_W-1:0] alloc_idx,
  output logic              empty
);

  logic [NUM_SLOT-1:0] free_mask;

  function automatic logic [SLOT_W-1:0] lowest_free(input logic [NUM_SLOT-1:0] m);
    logic [SLOT_W-1:0] r;
    r = '0;
    for (int i = NUM_SLOT - 1; i >= 0; i--) begin
      if (m[i]) r = SLOT_W'(i);
    end
    return r;
  endfunction

  assign alloc_idx = lowest_free(free_mask);
  assign empty     = (free_mask == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_mask <= '1;
    end else begin
      if (alloc) free_mask[alloc_idx] <= 1'b0;
      if (rel)   free_mask[rel_idx]   <= 1'b1;
    end
  end

  // R10
  alloc_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !empty);

  // R1
  no_double_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel |-> !free_mask[rel_idx]);

endmodule

// File: rtl/dcs_rr_arb.sv
module dcs_rr_arb #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [IW-1:0] gnt_idx,
  output logic          any
);

  logic [IW-1:0] last_q;
  logic [N-1:0]  gnt;

  function automatic logic [IW-1:0] rr_pick(input logic [N-1:0] r, input logic [IW-1:0] lst);
    logic [IW-1:0] res;
    logic          hit;
    int            idx;
    res = '0;
    hit = 1'b0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(lst) + k) % N;
      if (!hit && r[idx]) begin
        res = IW'(idx);
        hit = 1'b1;
      end
    end
    return res;
  endfunction

  assign any     = |req;
  assign gnt_idx = rr_pick(req, last_q);

  always_comb begin
    gnt = '0;
    if (any) gnt[gnt_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= IW'(N - 1);
    else if (adv && any) last_q <= gnt_idx;
  end

  // R11
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R11
  grant_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

endmodule

// File: rtl/desc_chain_sched.sv
module desc_chain_sched
  import dcs_pkg::*;
#(
  parameter int NUM_CONN = 16,
  parameter int NUM_SLOT = 64,
  parameter int PTR_W    = 16,
  parameter int SQ_W     = 5,
  localparam int CONN_W  = $clog2(NUM_CONN),
  localparam int SLOT_W  = $clog2(NUM_SLOT)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [PTR_W-1:0]         in_ptr,
  input  logic [CONN_W-1:0]        in_conn,
  input  logic                     in_head,
  input  logic                     in_single,
  input  logic                     in_chained,
  input  logic                     in_mgmt,
  input  logic                     in_last,
  output logic                     in_stall,
  output logic                     in_err,
  input  logic [NUM_CONN*SQ_W-1:0] conn_sq_tbl,
  input  logic [SQ_W-1:0]          mgmt_sq,
  input  logic                     pop_req,
  output logic                     out_valid,
  output logic [PTR_W-1:0]         out_ptr,
  output logic [CONN_W-1:0]        out_conn,
  output logic                     out_last,
  output logic [SQ_W-1:0]          sts_queue,
  output logic                     sts_single,
  output logic                     sts_mgmt
);

  // slot storage
  logic [PTR_W-1:0]  s_ptr  [NUM_SLOT];
  logic [SLOT_W-1:0] s_next [NUM_SLOT];
  desc_flags_t       s_flg  [NUM_SLOT];

  // chain state
  logic [SLOT_W-1:0] c_head [NUM_CONN];
  logic [SLOT_W-1:0] c_tail [NUM_CONN];
  logic [NUM_CONN-1:0] c_ne;
  logic [NUM_CONN-1:0] c_mid;

  // named internal events
  logic              reject;
  logic              acc;
  logic              rej_fire;
  logic              pop_fire;
  logic              pool_empty;
  logic [SLOT_W-1:0] new_slot;
  logic [CONN_W-1:0] g_conn;
  logic              g_any;
  logic [SLOT_W-1:0] pop_slot;
  desc_flags_t       pop_flg;
  desc_flags_t       in_flg;

  assign in_flg   = '{single: in_single, mgmt: in_mgmt, last: in_last};
  assign reject   = in_head && (in_chained || (!in_single && c_mid[in_conn]));
  assign pop_fire = pop_req && g_any;
  assign in_stall = in_valid && (pop_fire || (pool_empty && !reject));
  assign acc      = in_valid && !in_stall && !reject;
  assign rej_fire = in_valid && !in_stall && reject;
  assign pop_slot = c_head[g_conn];
  assign pop_flg  = s_flg[pop_slot];

  dcs_slot_pool #(.NUM_SLOT(NUM_SLOT)) u_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc     (acc),
    .rel       (pop_fire),
    .rel_idx   (pop_slot),
    .alloc_idx (new_slot),
    .empty     (pool_empty)
  );

  dcs_rr_arb #(.N(NUM_CONN)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (c_ne),
    .adv     (pop_fire),
    .gnt_idx (g_conn),
    .any     (g_any)
  );

  // slot contents and links
  always_ff @(posedge clk) begin
    if (acc) begin
      s_ptr[new_slot] <= in_ptr;
      s_flg[new_slot] <= in_flg;
      if (c_ne[in_conn]) begin
        if (in_head) s_next[new_slot] <= c_head[in_conn];
        else         s_next[c_tail[in_conn]] <= new_slot;
      end
    end
  end

  // head and tail pointers
  always_ff @(posedge clk) begin
    if (acc) begin
      if (!c_ne[in_conn]) begin
        c_head[in_conn] <= new_slot;
        c_tail[in_conn] <= new_slot;
      end else if (in_head) begin
        c_head[in_conn] <= new_slot;
      end else begin
        c_tail[in_conn] <= new_slot;
      end
    end else if (pop_fire && (c_head[g_conn] != c_tail[g_conn])) begin
      c_head[g_conn] <= s_next[pop_slot];
    end
  end

  // occupancy and packet state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_ne   <= '0;
      c_mid  <= '0;
      in_err <= 1'b0;
    end else begin
      in_err <= rej_fire;
      if (acc) begin
        c_ne[in_conn] <= 1'b1;
      end else if (pop_fire) begin
        if (c_head[g_conn] == c_tail[g_conn]) c_ne[g_conn] <= 1'b0;
        c_mid[g_conn] <= next_mid(c_mid[g_conn], pop_flg);
      end
    end
  end

  // pop outputs and completion record
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_ptr    <= '0;
      out_conn   <= '0;
      out_last   <= 1'b0;
      sts_queue  <= '0;
      sts_single <= 1'b0;
      sts_mgmt   <= 1'b0;
    end else begin
      out_valid <= pop_fire;
      if (pop_fire) begin
        out_ptr    <= s_ptr[pop_slot];
        out_conn   <= g_conn;
        out_last   <= ends_packet(pop_flg);
        sts_single <= pop_flg.single;
        sts_mgmt   <= pop_flg.mgmt;
        sts_queue  <= pop_flg.mgmt ? mgmt_sq : conn_sq_tbl[g_conn*SQ_W +: SQ_W];
      end
    end
  end

  // R8
  mgmt_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && sts_mgmt |-> sts_queue == $past(mgmt_sq));

  // R5
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_err |-> $past(in_valid && in_head && (in_chained || !in_single)));

  // R12
  pop_blocks_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire && in_valid |-> !acc);

  // R7
  single_keeps_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire && pop_flg.single |=> c_mid[$past(g_conn)] == $past(c_mid[g_conn]));

endmodule

// File: tb/desc_chain_sched_bench.sv
module desc_chain_sched_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 16;
  localparam int NS = 64;
  localparam int PW = 16;
  localparam int QW = 5;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [PW-1:0] in_ptr = '0;
  logic [CW-1:0] in_conn = '0;
  logic in_head = 1'b0, in_single = 1'b0, in_chained = 1'b0, in_mgmt = 1'b0, in_last = 1'b0;
  logic in_stall, in_err;
  logic [NC*QW-1:0] conn_sq_tbl;
  logic [QW-1:0] mgmt_sq = 5'd31;
  logic pop_req = 1'b0;
  logic out_valid;
  logic [PW-1:0] out_ptr;
  logic [CW-1:0] out_conn;
  logic out_last;
  logic [QW-1:0] sts_queue;
  logic sts_single, sts_mgmt;

  int n_chk = 0;
  int n_fail = 0;
  int stall_seen = 0;
  logic got_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_chain_sched u_desc_chain_sched (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ptr(in_ptr), .in_conn(in_conn),
    .in_head(in_head), .in_single(in_single), .in_chained(in_chained), .in_mgmt(in_mgmt),
    .in_last(in_last), .in_stall(in_stall), .in_err(in_err), .conn_sq_tbl(conn_sq_tbl),
    .mgmt_sq(mgmt_sq), .pop_req(pop_req), .out_valid(out_valid), .out_ptr(out_ptr),
    .out_conn(out_conn), .out_last(out_last), .sts_queue(sts_queue),
    .sts_single(sts_single), .sts_mgmt(sts_mgmt)
  );

  function automatic logic [QW-1:0] conn_queue(input int c);
    return QW'(c + 2);
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic          is_pop;
    logic [CW-1:0] conn;
    logic [PW-1:0] ptr;
    logic          head, single, chained, mgmt, last;
    logic          e_err;
    logic [PW-1:0] e_ptr;
    logic          e_last, e_single, e_mgmt;
  } vec_t;

  function automatic vec_t vp(input int c, input int p, input logic h, input logic s,
                              input logic ch, input logic m, input logic l, input logic er);
    vec_t v;
    v = '0;
    v.conn = CW'(c); v.ptr = PW'(p); v.head = h; v.single = s;
    v.chained = ch; v.mgmt = m; v.last = l; v.e_err = er;
    return v;
  endfunction

  function automatic vec_t vq(input int c, input int p, input logic l, input logic s, input logic m);
    vec_t v;
    v = '0;
    v.is_pop = 1'b1; v.conn = CW'(c); v.e_ptr = PW'(p);
    v.e_last = l; v.e_single = s; v.e_mgmt = m;
    return v;
  endfunction

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    vp(3, 16'h0101, 0, 0, 0, 0, 0, 0),  // R3 tail
    vp(3, 16'h0102, 0, 0, 0, 0, 1, 0),  // R3 tail
    vp(3, 16'h0A01, 1, 1, 0, 1, 0, 0),  // R4 head, single, mgmt
    vp(3, 16'h0B00, 1, 0, 1, 0, 0, 1),  // R5 head with chain: rejected
    vq(3, 16'h0A01, 1, 1, 1),           // R4 R7 R8 R9
    vq(3, 16'h0101, 0, 0, 0),           // R3 now mid-packet
    vp(3, 16'h0C00, 1, 0, 0, 0, 0, 1),  // R6 non-single head mid-packet
    vp(3, 16'h0C01, 1, 1, 0, 0, 0, 0),  // R6 single head accepted
    vq(3, 16'h0C01, 1, 1, 0),           // R7 single ends packet
    vq(3, 16'h0102, 1, 0, 0)            // R3 rest of packet
  };

  task automatic push(input int c, input int p, input logic h, input logic s,
                      input logic ch, input logic m, input logic l);
    @(negedge clk);
    in_valid = 1'b1; in_conn = CW'(c); in_ptr = PW'(p); in_head = h;
    in_single = s; in_chained = ch; in_mgmt = m; in_last = l;
    #1;
    while (in_stall) begin
      stall_seen++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    got_err = in_err;
  endtask

  task automatic pop();
    @(negedge clk);
    pop_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pop_req = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) conn_sq_tbl[c*QW +: QW] = conn_queue(c);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(in_err == 1'b0, "R1 in_err", int'(in_err), 0);
    check(in_stall == 1'b0, "R1 in_stall", int'(in_stall), 0);
    pop();
    check(out_valid == 1'b0, "R11 empty pop", int'(out_valid), 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      if (!VEC[i].is_pop) begin
        push(VEC[i].conn, VEC[i].ptr, VEC[i].head, VEC[i].single,
             VEC[i].chained, VEC[i].mgmt, VEC[i].last);
        check(got_err == VEC[i].e_err, "R5/R6 err", int'(got_err), int'(VEC[i].e_err));
      end else begin
        pop();
        check(out_valid && out_ptr == VEC[i].e_ptr, "R3/R4 ptr", int'(out_ptr), int'(VEC[i].e_ptr));
        check(out_conn == VEC[i].conn, "R11 conn", int'(out_conn), int'(VEC[i].conn));
        check(out_last == VEC[i].e_last, "R7 last", int'(out_last), int'(VEC[i].e_last));
        check(sts_single == VEC[i].e_single && sts_mgmt == VEC[i].e_mgmt, "R9 record",
              int'({sts_single, sts_mgmt}), int'({VEC[i].e_single, VEC[i].e_mgmt}));
        check(sts_queue == (VEC[i].e_mgmt ? mgmt_sq : conn_queue(int'(VEC[i].conn))),
              "R8 queue", int'(sts_queue),
              int'(VEC[i].e_mgmt ? mgmt_sq : conn_queue(int'(VEC[i].conn))));
      end
    end
    pop();
    check(out_valid == 1'b0, "R5 rejected not linked", int'(out_valid), 0);

    // R11 round robin: last grant was connection 3
    push(1, 16'h0011, 0, 0, 0, 0, 0);
    push(1, 16'h0012, 0, 0, 0, 0, 1);
    push(5, 16'h0051, 0, 0, 0, 0, 1);
    push(9, 16'h0091, 0, 0, 0, 0, 1);
    begin
      int exp_p [4] = '{16'h0051, 16'h0091, 16'h0011, 16'h0012};
      int exp_c [4] = '{5, 9, 1, 1};
      for (int k = 0; k < 4; k++) begin
        pop();
        check(out_valid && out_ptr == PW'(exp_p[k]) && out_conn == CW'(exp_c[k]),
              "R11 order", int'(out_ptr), exp_p[k]);
      end
    end

    // R12 insert during pop cycle
    push(2, 16'h0021, 0, 0, 0, 0, 1);
    @(negedge clk);
    pop_req = 1'b1;
    in_valid = 1'b1; in_conn = 4'd2; in_ptr = 16'h0022; in_head = 1'b0;
    in_single = 1'b0; in_chained = 1'b0; in_mgmt = 1'b0; in_last = 1'b1;
    #1;
    check(in_stall == 1'b1, "R12 stall in pop cycle", int'(in_stall), 1);
    @(posedge clk);
    @(negedge clk);
    pop_req = 1'b0;
    check(out_valid && out_ptr == 16'h0021, "R12 pop latency", int'(out_ptr), 16'h0021);
    #1;
    check(in_stall == 1'b0, "R2 released", int'(in_stall), 0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    pop();
    check(out_valid && out_ptr == 16'h0022, "R2 held entry taken", int'(out_ptr), 16'h0022);

    // R1 R10 fill every slot
    stall_seen = 0;
    for (int k = 0; k < NS; k++) push(7, k, 0, 0, 0, 0, 1);
    check(stall_seen == 0, "R1 64 free slots", stall_seen, 0);
    @(negedge clk);
    in_valid = 1'b1; in_conn = 4'd7; in_ptr = 16'h0099; in_last = 1'b1;
    #1;
    check(in_stall == 1'b1, "R10 stall when full", int'(in_stall), 1);
    @(negedge clk);
    #1;
    check(in_stall == 1'b1, "R10 stall held", int'(in_stall), 1);
    pop_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pop_req = 1'b0;
    check(out_valid && out_ptr == 16'h0000, "R10 pop while full", int'(out_ptr), 0);
    #1;
    check(in_stall == 1'b0, "R10 slot freed", int'(in_stall), 0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    begin
      int bad = 0;
      for (int k = 1; k <= NS; k++) begin
        pop();
        if (!out_valid || out_ptr != ((k == NS) ? 16'h0099 : PW'(k))) bad++;
      end
      check(bad == 0, "R3 full chain order", bad, 0);
    end
    pop();
    check(out_valid == 1'b0, "R1 drained", int'(out_valid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule